// File: doc/BRIEF.md
# Circular Queue Pointer Tracker for Arbitrary Depth

This block holds the read (head) and write (tail) positions of a circular queue whose depth is a parameter that may be any value of two or more, including values that are not a power of two such as 12. Each position is kept as a slot number from 0 to DEPTH-1 together with a one-bit lap flag. The flag changes each time the position passes the last slot and returns to slot 0. Because the lap flag is kept apart from the slot number, the block never relies on binary overflow to wrap.

Every cycle the surrounding logic presents how many entries it writes and how many it removes. The block moves both positions by those amounts. From the two positions it derives the number of used entries and the number of free entries. It also gives full and empty indications, a check that the write position has not overtaken the read position, and a per-slot occupancy map. A flush clears both positions. The entry storage itself lives outside this block.

Top module: `cq_ptr_track`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, used_o is 0, free_o is DEPTH, occ_mask_o is all zeros and err_o is 0.
- R2: When no flush or error is present, an enqueue count k (0 to DEPTH) advances the tail by k, and used_o rises by k in the following cycle.
- R3: A dequeue count advances the head in the same cycle as any enqueue. The next used_o equals the old used_o plus the enqueue count minus the dequeue count.
- R4: Slot positions wrap modulo DEPTH and the lap flag toggles at each wrap. used_o and occ_mask_o stay correct across any number of wraps, including a single step of exactly DEPTH.
- R5: free_o always equals DEPTH minus used_o.
- R6: full_o is 1 exactly when used_o equals DEPTH. In that state occ_mask_o has all DEPTH bits set.
- R7: empty_o is 1 exactly when used_o is 0. In that state occ_mask_o is all zeros.
- R8: Bit i of occ_mask_o is 1 exactly when slot i lies in the circular range that starts at the head slot and ends one slot before the tail slot.
- R9: order_ok_o is 1 in every state the block can reach through legal traffic.
- R10: A flush_i seen at a clock edge places both positions at slot 0 with lap flag 0 in the next cycle. It takes priority over any enqueue or dequeue count in that cycle, so a later enqueue of 3 fills slots 0, 1 and 2.
- R11: Without flush_i, err_o is 1 in the same cycle whenever the enqueue count exceeds free_o or the dequeue count exceeds used_o. Both positions are then left unchanged at the next edge.
- R12: used_o, free_o and both count inputs are ceil(log2(DEPTH+1)) bits wide, so a full count of DEPTH can be represented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Return both positions to slot 0 |
| enq_cnt_i | input | CW | Entries written this cycle |
| deq_cnt_i | input | CW | Entries removed this cycle |
| used_o | output | CW | Occupied entry count |
| free_o | output | CW | Free entry count |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |
| order_ok_o | output | 1 | Tail is at or after head |
| occ_mask_o | output | DEPTH | One bit per occupied slot |
| err_o | output | 1 | Count request out of range this cycle |

## Verification
A wrong lap flag or slot number shows at the ports in the cycle right after the faulty update. It appears as a used count that is off by DEPTH or by the wrap remainder, as a full/empty swap, or as an inverted occupancy map. A faulty wrap only becomes visible once the traffic crosses slot DEPTH-1. For that reason the stimulus drives many laps, and also single steps of exactly DEPTH, at the default non-power-of-two depth. After each edge the occupancy map is compared slot by slot against a model built on unbounded entry counters, so a misplaced head or tail is detected within one cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [1:0] {
        ACT_STEP   = 2'd0,
        ACT_FLUSH  = 2'd1,
        ACT_REJECT = 2'd2
    } act_e;

endpackage

// File: rtl/cq_ptr_adv.sv
module cq_ptr_adv #(
    parameter int DEPTH = 12,
    parameter int IW    = 4,
    parameter int CW    = 4
) (
    input  logic          flag_i,
    input  logic [IW-1:0] idx_i,
    input  logic [CW-1:0] step_i,
    output logic          flag_o,
    output logic [IW-1:0] idx_o
);
    localparam int SW = CW + 1;

    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;
    logic          crossed;

    always_comb begin
        sum     = SW'(idx_i) + SW'(step_i);
        crossed = (sum >= SW'(DEPTH));
        wrapped = crossed ? (sum - SW'(DEPTH)) : sum;
        idx_o   = IW'(wrapped);
        flag_o  = flag_i ^ crossed;
    end

endmodule

// File: rtl/cq_ptr_dist.sv
module cq_ptr_dist #(
    parameter int DEPTH = 12,
    parameter int IW    = 4,
    parameter int CW    = 4
) (
    input  logic          t_flag_i,
    input  logic [IW-1:0] t_idx_i,
    input  logic          h_flag_i,
    input  logic [IW-1:0] h_idx_i,
    output logic [CW-1:0] dist_o,
    output logic          order_ok_o
);
    always_comb begin
        if (t_flag_i == h_flag_i) begin
            dist_o     = CW'(t_idx_i) - CW'(h_idx_i);
            order_ok_o = (t_idx_i >= h_idx_i);
        end else begin
            dist_o     = CW'(DEPTH) + CW'(t_idx_i) - CW'(h_idx_i);
            order_ok_o = (t_idx_i <= h_idx_i);
        end
    end

endmodule

// File: rtl/cq_range_mask.sv
module cq_range_mask #(
    parameter int DEPTH = 12,
    parameter int IW    = 4
) (
    input  logic             s_flag_i,
    input  logic [IW-1:0]    s_idx_i,
    input  logic             e_flag_i,
    input  logic [IW-1:0]    e_idx_i,
    output logic [DEPTH-1:0] mask_o
);
    logic [DEPTH-1:0] below_s;
    logic [DEPTH-1:0] below_e;
    logic [DEPTH-1:0] span;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        assign below_s[i] = (s_idx_i > IW'(i));
        assign below_e[i] = (e_idx_i > IW'(i));
    end

    assign span   = below_s ^ below_e;
    assign mask_o = (s_flag_i == e_flag_i) ? span : ~span;

endmodule

// File: rtl/cq_ptr_track.sv
module cq_ptr_track #(
    parameter int DEPTH = 12,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [CW-1:0]    enq_cnt_i,
    input  logic [CW-1:0]    deq_cnt_i,
    output logic [CW-1:0]    used_o,
    output logic [CW-1:0]    free_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             order_ok_o,
    output logic [DEPTH-1:0] occ_mask_o,
    output logic             err_o
);
    import cq_pkg::*;

    typedef struct packed {
        logic          flag;
        logic [IW-1:0] idx;
    } ptr_t;

    typedef struct packed {
        ptr_t head;
        ptr_t tail;
    } state_t;

    state_t st_d, st_q;
    ptr_t   head_nx, tail_nx;
    act_e   act;

    cq_ptr_adv #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_adv_tail (
        .flag_i (st_q.tail.flag),
        .idx_i  (st_q.tail.idx),
        .step_i (enq_cnt_i),
        .flag_o (tail_nx.flag),
        .idx_o  (tail_nx.idx)
    );

    cq_ptr_adv #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_adv_head (
        .flag_i (st_q.head.flag),
        .idx_i  (st_q.head.idx),
        .step_i (deq_cnt_i),
        .flag_o (head_nx.flag),
        .idx_o  (head_nx.idx)
    );

    cq_ptr_dist #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_dist (
        .t_flag_i   (st_q.tail.flag),
        .t_idx_i    (st_q.tail.idx),
        .h_flag_i   (st_q.head.flag),
        .h_idx_i    (st_q.head.idx),
        .dist_o     (used_o),
        .order_ok_o (order_ok_o)
    );

    cq_range_mask #(.DEPTH(DEPTH), .IW(IW)) u_mask (
        .s_flag_i (st_q.head.flag),
        .s_idx_i  (st_q.head.idx),
        .e_flag_i (st_q.tail.flag),
        .e_idx_i  (st_q.tail.idx),
        .mask_o   (occ_mask_o)
    );

    assign free_o  = CW'(DEPTH) - used_o;
    assign empty_o = (st_q.head == st_q.tail);
    assign full_o  = (st_q.head.flag != st_q.tail.flag) &&
                     (st_q.head.idx == st_q.tail.idx);

    always_comb begin
        if (flush_i)
            act = ACT_FLUSH;
        else if ((enq_cnt_i > free_o) || (deq_cnt_i > used_o))
            act = ACT_REJECT;
        else
            act = ACT_STEP;

        st_d  = st_q;
        err_o = 1'b0;
        case (act)
            ACT_FLUSH:  st_d = '0;
            ACT_REJECT: err_o = 1'b1;
            default: begin
                st_d.head = head_nx;
                st_d.tail = tail_nx;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/cq_ptr_track_chk.sv
module cq_ptr_track_chk #(
    parameter int DEPTH = 12,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             err_o,
    input logic [CW-1:0]    used_o,
    input logic [CW-1:0]    free_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             order_ok_o,
    input logic [DEPTH-1:0] occ_mask_o
);
    a_r5_free_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ((CW+1)'(used_o) + (CW+1)'(free_o)) == (CW+1)'(DEPTH));

    a_r6_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (&occ_mask_o) && (used_o == CW'(DEPTH)));

    a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (occ_mask_o == '0) && !full_o);

    a_r8_mask_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ_mask_o) == int'(used_o));

    a_r9_order: assert property (@(posedge clk) disable iff (!rst_n)
        order_ok_o);

    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o && (used_o == '0));

    a_r11_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !flush_i) |=> $stable(occ_mask_o) && $stable(used_o));

endmodule

bind cq_ptr_track cq_ptr_track_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .err_o      (err_o),
    .used_o     (used_o),
    .free_o     (free_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .order_ok_o (order_ok_o),
    .occ_mask_o (occ_mask_o)
);

// File: tb/cq_ptr_track_test.sv
`timescale 1ns/1ps
module cq_ptr_track_test;
    localparam int DEPTH = 12;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_i = 1'b0;
    logic [CW-1:0]    enq_cnt_i = '0;
    logic [CW-1:0]    deq_cnt_i = '0;
    logic [CW-1:0]    used_o, free_o;
    logic             full_o, empty_o, order_ok_o, err_o;
    logic [DEPTH-1:0] occ_mask_o;

    int n_chk = 0;
    int n_bad = 0;
    longint hd = 0;
    longint tl = 0;

    always #2 clk = ~clk;

    cq_ptr_track #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .enq_cnt_i(enq_cnt_i), .deq_cnt_i(deq_cnt_i),
        .used_o(used_o), .free_o(free_o), .full_o(full_o),
        .empty_o(empty_o), .order_ok_o(order_ok_o),
        .occ_mask_o(occ_mask_o), .err_o(err_o)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [DEPTH-1:0] model_mask();
        logic [DEPTH-1:0] m = '0;
        for (longint j = hd; j < tl; j++) m[int'(j % DEPTH)] = 1'b1;
        return m;
    endfunction

    task automatic check_state(string ctx);
        longint u = tl - hd;
        check({ctx, " R2 used"}, used_o, u);
        check({ctx, " R5 free"}, free_o, DEPTH - u);
        check({ctx, " R6 full"}, full_o, (u == DEPTH) ? 1 : 0);
        check({ctx, " R7 empty"}, empty_o, (u == 0) ? 1 : 0);
        check({ctx, " R8 mask"}, occ_mask_o, model_mask());
        check({ctx, " R9 order"}, order_ok_o, 1);
    endtask

    // drive at negedge, check err, take edge, update model, check state
    task automatic step(string ctx, bit fl, int enq, int deq);
        bit exp_err;
        flush_i   = fl;
        enq_cnt_i = CW'(enq);
        deq_cnt_i = CW'(deq);
        #1;
        exp_err = !fl && ((enq > DEPTH - (tl - hd)) || (deq > (tl - hd)));
        check({ctx, " R11 err"}, err_o, exp_err);
        @(posedge clk);
        if (fl) begin
            hd = 0; tl = 0;
        end else if (!exp_err) begin
            tl += enq; hd += deq;
        end
        @(negedge clk);
        flush_i = 1'b0; enq_cnt_i = '0; deq_cnt_i = '0;
        check_state(ctx);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err", err_o, 0);
        check_state("R1 reset");

        step("R2 enq5", 0, 5, 0);
        step("R3 deq2", 0, 0, 2);
        step("R3 both", 0, 4, 3);
        step("R6 fill", 0, 8, 0);
        check("R12 full count", used_o, DEPTH);
        step("R11 over enq", 0, 1, 0);
        step("R4 drain cross", 0, 0, 7);
        step("R7 drain", 0, 0, 5);
        step("R11 over deq", 0, 0, 1);
        step("R4 whole", 0, DEPTH, 0);
        step("R4 whole out", 0, 0, DEPTH);
        step("R4 whole both", 0, DEPTH, 0);
        step("R4 rotate", 0, 3, 3);

        for (int i = 0; i < 300; i++) begin
            int u = int'(tl - hd);
            int e = $urandom_range(DEPTH - u, 0);
            int d = $urandom_range(u, 0);
            if (i % 37 == 5) e = DEPTH - u + 1;
            step("R4 traffic", 0, e, d);
        end

        step("R10 prefill", 0, 0, 0);
        step("R10 flush", 1, 4, 1);
        step("R10 after", 0, 3, 0);
        check("R10 slots", occ_mask_o, 7);
        step("R10 flush2", 1, 15, 15);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule